// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Execute Unit

This block is a single-cycle integer execute stage for a 32-bit processor with sixteen general registers. Each accepted 16-bit instruction selects one of thirteen arithmetic operations through an 8-bit opcode. The block computes a sum or a difference of destination register Ri and a second operand. That operand is either register Rj or a 4-bit immediate, widened with zeros or with ones depending on the opcode. The block then decides whether the result is written back to Ri and whether the four condition flags (negative, zero, overflow, carry) take new values. Flag-updating, flag-keeping and compare-only operations all share one adder.

The register file and the flag register are inside the block, so it can be exercised alone. A load port places a value in any register while no instruction commits.

Instructions arrive on a valid/ready stream, and the result leaves on a valid/ready stream. The result side is combinational from the instruction side, so `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. An instruction commits on the rising clock edge where `in_valid` and `out_ready` are both high. Until that edge the sender must hold `instr` steady. While `out_ready` is low, nothing in the register file or the flags changes. The result fields can be read in the same cycle the instruction is presented.

Top module: `intarith_exec`

## Requirements
- R1: Opcode 0xA6 writes Ri+Rj to Ri and sets all four flags from the addition.
- R2: Opcode 0xA7 writes Ri+Rj+C to Ri, where C is the current carry flag, and sets all four flags.
- R3: Opcodes 0xA4 and 0xA5 add the immediate in bits [7:4] to Ri and set all four flags. For 0xA4 the immediate is widened with zeros (0..15). For 0xA5 the upper 28 bits are ones (-16..-1).
- R4: Opcodes 0xA2 (register), 0xA0 (zero-widened immediate) and 0xA1 (ones-widened immediate) write the sum to Ri and leave all flags unchanged.
- R5: Opcode 0xAC writes Ri-Rj and sets the flags. Opcode 0xAD writes Ri-Rj-C and sets the flags. Opcode 0xAE writes Ri-Rj and leaves the flags unchanged.
- R6: Opcodes 0xAA (Rj), 0xA8 (zero-widened immediate) and 0xA9 (ones-widened immediate) compute Ri minus the operand, set the flags, and never write a register (`res_wr` low).
- R7: The flags are packed as {N,Z,V,C} in bits [3:0]. N is result bit 31. Z is set when the result is zero. V is set on signed two's-complement overflow. For additions, C is the carry out of bit 31. For subtractions and compares, C marks a borrow.
- R8: For any other opcode, `illegal` is high and `res_wr` is low, and committing the instruction changes no register and no flag.
- R9: `in_ready` equals `out_ready`. While `out_ready` is low, no register or flag changes.
- R10: A load on `ld_en` writes `ld_data` to register `ld_idx` only in a cycle where no instruction commits. A load in a committing cycle is dropped.
- R11: A synchronous reset clears all sixteen registers and the flags. A committed update is visible from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be taken (mirrors out_ready) |
| instr | input | 16 | Opcode [15:8], Rj or immediate [7:4], Ri [3:0] |
| out_valid | output | 1 | Result fields are meaningful |
| out_ready | input | 1 | Consumer accepts the result; gates commit |
| res_data | output | 32 | Sum or difference |
| res_wr | output | 1 | Result is written to Ri on commit |
| res_idx | output | 4 | Destination register index Ri |
| flags_next | output | 4 | Flags {N,Z,V,C} after this instruction |
| illegal | output | 1 | Opcode outside the supported set |
| flags | output | 4 | Current flag register {N,Z,V,C} |
| ld_en | input | 1 | Register load request |
| ld_idx | input | 4 | Register to load |
| ld_data | input | 32 | Value to load |

## Verification
On every cycle, the assertions check the following at the flag register and the write strobe:
- A committed instruction moves the flags to the announced `flags_next`.
- Flag-keeping opcodes, illegal opcodes and stalled cycles leave the flags as they were.
- Compares and illegal opcodes never raise the write strobe.
- Reset clears the flags.

The arithmetic itself can only be shown by the bench's scenarios: the carry and borrow edges, signed overflow in both directions, the two immediate widenings, and the carry feeding ADDC and SUBC. The same holds for register contents after stalls, dropped loads and reset. The bench reads those back through a flag-keeping add of zero.

// File: rtl/intarith_pkg.sv
package intarith_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 8;
  localparam int FIELD_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADDK_IZ = 8'hA0,
    OP_ADDK_IO = 8'hA1,
    OP_ADDK_R  = 8'hA2,
    OP_ADD_IZ  = 8'hA4,
    OP_ADD_IO  = 8'hA5,
    OP_ADD_R   = 8'hA6,
    OP_ADDC_R  = 8'hA7,
    OP_CMP_IZ  = 8'hA8,
    OP_CMP_IO  = 8'hA9,
    OP_CMP_R   = 8'hAA,
    OP_SUB_R   = 8'hAC,
    OP_SUBC_R  = 8'hAD,
    OP_SUBK_R  = 8'hAE
  } opcode_e;

  typedef struct packed {
    logic legal;
    logic sub;
    logic use_imm;
    logic imm_ones;
    logic use_carry;
    logic set_flags;
    logic wb;
  } ctrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/intarith_decode.sv
module intarith_decode
  import intarith_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.legal = 1'b1;
    case (opcode)
      OP_ADDK_IZ: begin ctrl.use_imm = 1'b1; ctrl.wb = 1'b1; end
      OP_ADDK_IO: begin ctrl.use_imm = 1'b1; ctrl.imm_ones = 1'b1; ctrl.wb = 1'b1; end
      OP_ADDK_R:  begin ctrl.wb = 1'b1; end
      OP_ADD_IZ:  begin ctrl.use_imm = 1'b1; ctrl.set_flags = 1'b1; ctrl.wb = 1'b1; end
      OP_ADD_IO:  begin ctrl.use_imm = 1'b1; ctrl.imm_ones = 1'b1; ctrl.set_flags = 1'b1; ctrl.wb = 1'b1; end
      OP_ADD_R:   begin ctrl.set_flags = 1'b1; ctrl.wb = 1'b1; end
      OP_ADDC_R:  begin ctrl.use_carry = 1'b1; ctrl.set_flags = 1'b1; ctrl.wb = 1'b1; end
      OP_CMP_IZ:  begin ctrl.sub = 1'b1; ctrl.use_imm = 1'b1; ctrl.set_flags = 1'b1; end
      OP_CMP_IO:  begin ctrl.sub = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_ones = 1'b1; ctrl.set_flags = 1'b1; end
      OP_CMP_R:   begin ctrl.sub = 1'b1; ctrl.set_flags = 1'b1; end
      OP_SUB_R:   begin ctrl.sub = 1'b1; ctrl.set_flags = 1'b1; ctrl.wb = 1'b1; end
      OP_SUBC_R:  begin ctrl.sub = 1'b1; ctrl.use_carry = 1'b1; ctrl.set_flags = 1'b1; ctrl.wb = 1'b1; end
      OP_SUBK_R:  begin ctrl.sub = 1'b1; ctrl.wb = 1'b1; end
      default:    ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/intarith_adder.sv
module intarith_adder
  import intarith_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              sub,
  input  logic              use_carry,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum,
  output flags_t            fl
);

  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [DATA_W:0]   full;

  always_comb begin
    // subtraction as a + ~b + 1; a borrow-in removes the +1
    b_eff = sub ? ~op_b : op_b;
    if (sub) cin = use_carry ? ~carry_in : 1'b1;
    else     cin = use_carry ?  carry_in : 1'b0;
    full = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    sum  = full[DATA_W-1:0];
    fl.n = sum[DATA_W-1];
    fl.z = ~|sum;
    fl.v = (op_a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != op_a[DATA_W-1]);
    fl.c = sub ? ~full[DATA_W] : full[DATA_W];
  end

endmodule

// File: rtl/intarith_regfile.sv
module intarith_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data
);

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[w_idx] <= w_data;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

endmodule

// File: rtl/intarith_exec.sv
module intarith_exec
  import intarith_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int IDX_W = FIELD_W,
  localparam int NREG  = 1 << IDX_W,
  localparam int IMM_W = FIELD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [INSTR_W-1:0]  instr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   res_data,
  output logic                res_wr,
  output logic [IDX_W-1:0]    res_idx,
  output logic [3:0]          flags_next,
  output logic                illegal,
  output logic [3:0]          flags,
  input  logic                ld_en,
  input  logic [IDX_W-1:0]    ld_idx,
  input  logic [DATA_W-1:0]   ld_data
);

  logic [OPC_W-1:0]  opcode;
  logic [IMM_W-1:0]  src_field;
  logic [IDX_W-1:0]  dst_idx;
  ctrl_t             ctrl;
  logic              fire;
  logic [DATA_W-1:0] ri_val, rj_val, imm_ext, op_b, sum;
  flags_t            add_fl, flags_q, flags_d;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_idx;
  logic [DATA_W-1:0] rf_data;

  assign opcode    = instr[INSTR_W-1 -: OPC_W];
  assign src_field = instr[2*FIELD_W-1 -: FIELD_W];
  assign dst_idx   = instr[FIELD_W-1:0];

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign fire      = in_valid & out_ready;

  intarith_decode u_dec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  intarith_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra_idx  (dst_idx),
    .ra_data (ri_val),
    .rb_idx  (src_field),
    .rb_data (rj_val),
    .we      (rf_we),
    .w_idx   (rf_idx),
    .w_data  (rf_data)
  );

  assign imm_ext = ctrl.imm_ones ? {{(DATA_W-IMM_W){1'b1}}, src_field}
                                 : {{(DATA_W-IMM_W){1'b0}}, src_field};
  assign op_b    = ctrl.use_imm ? imm_ext : rj_val;

  intarith_adder #(.DATA_W(DATA_W)) u_add (
    .op_a      (ri_val),
    .op_b      (op_b),
    .sub       (ctrl.sub),
    .use_carry (ctrl.use_carry),
    .carry_in  (flags_q.c),
    .sum       (sum),
    .fl        (add_fl)
  );

  assign flags_d    = (ctrl.legal && ctrl.set_flags) ? add_fl : flags_q;
  assign res_data   = sum;
  assign res_idx    = dst_idx;
  assign res_wr     = in_valid & ctrl.legal & ctrl.wb;
  assign illegal    = in_valid & ~ctrl.legal;
  assign flags_next = flags_d;
  assign flags      = flags_q;

  // committing instruction owns the write port; a load only fills idle cycles
  always_comb begin
    if (fire) begin
      rf_we   = ctrl.legal & ctrl.wb;
      rf_idx  = dst_idx;
      rf_data = sum;
    end else begin
      rf_we   = ld_en;
      rf_idx  = ld_idx;
      rf_data = ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       flags_q <= '0;
    else if (fire) flags_q <= flags_d;
  end

endmodule

// File: rtl/intarith_exec_chk.sv
module intarith_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        out_ready,
  input logic [15:0] instr,
  input logic        res_wr,
  input logic        illegal,
  input logic [3:0]  flags,
  input logic [3:0]  flags_next
);

  p_illegal_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !res_wr);

  p_illegal_keeps_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_ready && illegal) |=> flags == $past(flags));

  p_keep_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_ready && (instr[15:8] inside {8'hA0, 8'hA1, 8'hA2, 8'hAE}))
    |=> flags == $past(flags));

  p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (instr[15:8] inside {8'hA8, 8'hA9, 8'hAA})) |-> !res_wr);

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !out_ready) |=> flags == $past(flags));

  p_commit_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_ready) |=> flags == $past(flags_next));

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> flags == 4'h0);

endmodule

bind intarith_exec intarith_exec_chk u_chk (.*);

// File: tb/tb_intarith_exec.sv
module tb_intarith_exec;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] instr;
  logic [31:0] res_data;
  logic        res_wr, illegal;
  logic [3:0]  res_idx, flags_next, flags;
  logic        ld_en;
  logic [3:0]  ld_idx;
  logic [31:0] ld_data;

  always #2 clk = ~clk;

  intarith_exec dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .instr(instr),
    .out_valid(out_valid), .out_ready(out_ready), .res_data(res_data), .res_wr(res_wr),
    .res_idx(res_idx), .flags_next(flags_next), .illegal(illegal), .flags(flags),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_regs [16];
  logic [3:0]  m_fl;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'hA6: return "R1";
      8'hA7: return "R2";
      8'hA4, 8'hA5: return "R3";
      8'hA0, 8'hA1, 8'hA2: return "R4";
      8'hAC, 8'hAD, 8'hAE: return "R5";
      8'hA8, 8'hA9, 8'hAA: return "R6";
      default: return "R8";
    endcase
  endfunction

  // behavioural reference: widened arithmetic, flags from range tests
  task automatic model_eval(input logic [15:0] ins, output logic [31:0] res, output logic wr,
                            output logic [3:0] nf, output logic leg);
    logic [7:0]  op;
    logic [3:0]  s, d;
    logic        sub, imm, ones, cy, setf, wb, ci, n, z, v, c;
    logic [31:0] a, b;
    logic [63:0] u;
    longint      sr;
    op = ins[15:8]; s = ins[7:4]; d = ins[3:0];
    leg = 1'b1; sub = 0; imm = 0; ones = 0; cy = 0; setf = 1; wb = 1;
    case (op)
      8'hA0: begin imm = 1; setf = 0; end
      8'hA1: begin imm = 1; ones = 1; setf = 0; end
      8'hA2: setf = 0;
      8'hA4: imm = 1;
      8'hA5: begin imm = 1; ones = 1; end
      8'hA6: ;
      8'hA7: cy = 1;
      8'hA8: begin sub = 1; imm = 1; wb = 0; end
      8'hA9: begin sub = 1; imm = 1; ones = 1; wb = 0; end
      8'hAA: begin sub = 1; wb = 0; end
      8'hAC: sub = 1;
      8'hAD: begin sub = 1; cy = 1; end
      8'hAE: begin sub = 1; setf = 0; end
      default: begin leg = 0; setf = 0; wb = 0; end
    endcase
    a  = m_regs[d];
    b  = imm ? (ones ? (32'hFFFFFFF0 | {28'd0, s}) : {28'd0, s}) : m_regs[s];
    ci = cy ? m_fl[0] : 1'b0;
    if (!sub) begin
      u   = {32'd0, a} + {32'd0, b} + {63'd0, ci};
      res = u[31:0];
      c   = u[32];
      sr  = longint'($signed(a)) + longint'($signed(b)) + longint'(ci);
    end else begin
      res = a - b - {31'd0, ci};
      c   = ({32'd0, a} < ({32'd0, b} + {63'd0, ci}));
      sr  = longint'($signed(a)) - longint'($signed(b)) - longint'(ci);
    end
    v  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    n  = res[31];
    z  = (res == 32'd0);
    nf = (leg && setf) ? {n, z, v, c} : m_fl;
    wr = leg && wb;
  endtask

  task automatic step(input logic [15:0] ins, input logic v, input logic rdy,
                      input logic le, input logic [3:0] li, input logic [31:0] ld,
                      input string xtag, input logic xr_en, input logic [31:0] xres,
                      input logic xf_en, input logic [3:0] xfl);
    logic [31:0] res;
    logic        wr, leg;
    logic [3:0]  nf;
    string       req;
    @(negedge clk);
    in_valid = v; out_ready = rdy; instr = ins; ld_en = le; ld_idx = li; ld_data = ld;
    #1;
    model_eval(ins, res, wr, nf, leg);
    req = req_of(ins[15:8]);
    chk("R11", "flags state", {28'd0, flags}, {28'd0, m_fl});
    chk("R9", "in_ready", {31'd0, in_ready}, {31'd0, rdy});
    chk("R9", "out_valid", {31'd0, out_valid}, {31'd0, v});
    if (v) begin
      chk("R8", "illegal", {31'd0, illegal}, {31'd0, !leg});
      chk(req, "res_wr", {31'd0, res_wr}, {31'd0, wr});
      if (leg) begin
        chk(req, "res_data", res_data, res);
        chk(req, "res_idx", {28'd0, res_idx}, {28'd0, ins[3:0]});
        chk({req, "/R7"}, "flags_next", {28'd0, flags_next}, {28'd0, nf});
      end
    end
    if (xr_en) chk(xtag, "explicit result", res_data, xres);
    if (xf_en) chk(xtag, "explicit flags_next", {28'd0, flags_next}, {28'd0, xfl});
    @(posedge clk);
    if (v && rdy) begin
      if (wr) m_regs[ins[3:0]] = res;
      m_fl = nf;
    end else if (le) begin
      m_regs[li] = ld;
    end
  endtask

  task automatic ex(input logic [15:0] ins, input string tag, input logic [31:0] xres, input logic [3:0] xfl);
    step(ins, 1, 1, 0, 0, 0, tag, 1, xres, 1, xfl);
  endtask

  task automatic exf(input logic [15:0] ins, input string tag, input logic [3:0] xfl);
    step(ins, 1, 1, 0, 0, 0, tag, 0, 0, 1, xfl);
  endtask

  task automatic load(input logic [3:0] idx, input logic [31:0] val);
    step(16'h0000, 0, 1, 1, idx, val, "", 0, 0, 0, 0);
  endtask

  // read a register back with a flag-keeping add of zero (opcode 0xA0, imm 0)
  task automatic rb(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    step({8'hA0, 4'h0, idx}, 1, 1, 0, 0, 0, tag, 1, exp, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 1; ld_en = 0; instr = '0; ld_idx = '0; ld_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 16; i++) m_regs[i] = '0;
    m_fl = '0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] ops [14];
    ops = '{8'hA0, 8'hA1, 8'hA2, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hA8, 8'hA9,
            8'hAA, 8'hAC, 8'hAD, 8'hAE, 8'hA3};
    rst = 1; in_valid = 0; out_ready = 1; ld_en = 0; instr = '0; ld_idx = '0; ld_data = '0;
    for (int i = 0; i < 16; i++) m_regs[i] = 'x;
    m_fl = 'x;
    do_reset();
    #1;
    chk("R11", "flags after reset", {28'd0, flags}, 32'd0);
    rb(4'd9, 32'd0, "R11");

    load(1, 32'hFFFFFFFF); load(2, 32'h1); load(3, 32'h7FFFFFFF); load(4, 32'h10);
    load(5, 32'h0); load(6, 32'h1); load(8, 32'h80000000);

    ex({8'hA6, 4'd2, 4'd1}, "R1", 32'h0, 4'b0101);          // wrap to zero, carry out
    ex({8'hA7, 4'd2, 4'd3}, "R2", 32'h80000001, 4'b1010);   // +1 +C, signed overflow
    ex({8'hA5, 4'hF, 4'd4}, "R3", 32'h0000000F, 4'b0001);   // 0x10 + (-1)
    ex({8'hA4, 4'hF, 4'd4}, "R3", 32'h0000001E, 4'b0000);   // 0xF + 15
    ex({8'hA2, 4'd3, 4'd4}, "R4", 32'h8000001F, 4'b0000);   // flags kept
    ex({8'hA1, 4'h0, 4'd2}, "R4", 32'hFFFFFFF1, 4'b0000);   // 1 + (-16)
    ex({8'hAC, 4'd6, 4'd5}, "R5", 32'hFFFFFFFF, 4'b1001);   // 0 - 1 borrows
    ex({8'hAD, 4'd6, 4'd5}, "R5", 32'hFFFFFFFD, 4'b1000);   // -1 - 1 - C
    ex({8'hAE, 4'd6, 4'd5}, "R5", 32'hFFFFFFFC, 4'b1000);   // flags kept
    ex({8'hAA, 4'd5, 4'd5}, "R6", 32'h0, 4'b0100);          // equal
    rb(4'd5, 32'hFFFFFFFC, "R6");
    exf({8'hA8, 4'd3, 4'd6}, "R6", 4'b1001);                // 1 - 3
    exf({8'hA9, 4'hF, 4'd6}, "R6", 4'b0001);                // 1 - (-1) borrows unsigned
    rb(4'd6, 32'h1, "R6");
    ex({8'hAC, 4'd6, 4'd8}, "R7", 32'h7FFFFFFF, 4'b0010);   // negative overflow on subtract

    exf({8'hA3, 4'd6, 4'd6}, "R8", 4'b0010);
    exf({8'hFF, 4'd6, 4'd8}, "R8", 4'b0010);
    rb(4'd6, 32'h1, "R8");
    rb(4'd8, 32'h7FFFFFFF, "R8");

    step({8'hA6, 4'd6, 4'd6}, 1, 0, 0, 0, 0, "R9", 0, 0, 0, 0);
    step({8'hA6, 4'd6, 4'd6}, 1, 0, 0, 0, 0, "R9", 0, 0, 0, 0);
    rb(4'd6, 32'h1, "R9");

    step({8'hA0, 4'h0, 4'd7}, 1, 1, 1, 4'd7, 32'hDEAD0000, "R10", 0, 0, 0, 0);
    rb(4'd7, 32'h0, "R10");
    step(16'h0, 1, 0, 1, 4'd7, 32'hDEAD0001, "R10", 0, 0, 0, 0);
    rb(4'd7, 32'hDEAD0001, "R10");

    for (int k = 0; k < 1500; k++) begin
      logic [15:0] ins;
      ins = {ops[$urandom_range(0, 13)], 4'($urandom), 4'($urandom)};
      if ($urandom_range(0, 9) == 0) ins[15:8] = 8'($urandom);
      step(ins, $urandom_range(0, 7) != 0, $urandom_range(0, 5) != 0,
           $urandom_range(0, 4) == 0, 4'($urandom), $urandom(), "", 0, 0, 0, 0);
    end
    for (int i = 0; i < 16; i++) rb(4'(i), m_regs[i], "R4");

    load(4'd3, 32'h12345678);
    do_reset();
    #1;
    chk("R11", "flags after second reset", {28'd0, flags}, 32'd0);
    rb(4'd3, 32'h0, "R11");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule